// File: doc/BRIEF.md
# Dual-Page Translation Lookaside Buffer

This block is a fully associative translation lookaside buffer. Each entry covers an aligned pair of neighbouring pages, one even and one odd, that share a virtual tag. Each entry also holds its own page-size mask, an address-space identifier and a global flag. The two halves of an entry each have their own frame number, valid bit and dirty bit. A lookup takes a virtual address, a read/write flag and the current 8-bit address-space identifier. It compares the address against every entry in parallel, in one combinational pass, and returns a physical address, a write-permission flag and a two-bit result code.

Software fills the buffer through a write port. When the load strobe is high, one whole entry is written at the rising clock edge, into the slot that an index selects. The surrounding pipeline turns the result code into its own exception handling. Segment decoding and page-table walks are left to other blocks.

Top module: `dual_page_tlb`

## Requirements
- R1: After reset every slot is unloaded, and any lookup reports result code 2'b01 (miss) until a slot is written.
- R2: A slot takes part in a match only if its global flag is set or its stored 8-bit identifier equals `curAsid`.
- R3: The minimum page is 4 KB. The comparison mask is the slot's page mask ORed with address bits 12:0, and the tag match ignores every address bit under that mask.
- R4: The half is picked by the highest address bit under the comparison mask. A 1 in that bit selects the odd half. For 4 KB pages this is bit 12; with page-mask bits 14:13 set (16 KB pages) it is bit 14.
- R5: If the selected half's valid bit is clear, the result is 2'b10 (invalid), for reads and writes alike.
- R6: A read of a valid half gives 2'b00 (hit). A write to a valid half gives 2'b00 only if its dirty bit is set, and 2'b11 (modify fault) otherwise.
- R7: On a hit, `physAddr` is the selected frame number ORed with the address bits below the half-page boundary, and `writeOk` equals that half's dirty bit.
- R8: If no slot matches, the result is 2'b01 (miss).
- R9: If several slots match, the lowest-indexed one decides the outcome.
- R10: When the result is not a hit, `physAddr` is zero and `writeOk` is low.
- R11: With `wrEn` high, the slot at `wrIndex` takes the new contents at the rising edge, replacing whatever it held, and later lookups see only the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkVaddr | input | VA_W | Virtual address to translate |
| lkWrite | input | 1 | 1 = store access, 0 = load access |
| curAsid | input | ASID_W | Current address-space identifier |
| wrEn | input | 1 | Load strobe for one slot |
| wrIndex | input | IDX_W | Slot to load |
| wrVpn | input | VA_W | Virtual tag of the page pair |
| wrMask | input | VA_W | Page mask (bits 13 and up give the size) |
| wrAsid | input | ASID_W | Identifier stored in the slot |
| wrGlobal | input | 1 | Global flag |
| wrPfnEven | input | PA_W | Frame base of the even half |
| wrValidEven | input | 1 | Even half valid |
| wrDirtyEven | input | 1 | Even half writable |
| wrPfnOdd | input | PA_W | Frame base of the odd half |
| wrValidOdd | input | 1 | Odd half valid |
| wrDirtyOdd | input | 1 | Odd half writable |
| physAddr | output | PA_W | Translated address, zero unless hit |
| writeOk | output | 1 | Write permission for the hit half |
| result | output | 2 | 00 hit, 01 miss, 10 invalid, 11 modify fault |

## Verification
The hardest case to reach is a lookup that several slots match while the winner is decided by identifier and index. It is set up by loading one virtual pair twice: once into a low slot tied to one identifier, and once into a higher slot marked global with other frames. Lookups under the matching identifier must return the low slot's frames. Lookups under any other identifier must fall through to the global slot. Then the low slot is overwritten with a new tag, and the earlier lookup must move to the global slot. Half selection with a large page is checked with a 16 KB mask, where the odd bit is bit 14 and not bit 12.

// File: rtl/tlbPkg.sv
package tlbPkg;

  typedef enum logic [1:0] {
    RES_HIT     = 2'b00,
    RES_MISS    = 2'b01,
    RES_INVALID = 2'b10,
    RES_MODIFY  = 2'b11
  } lookupRes_e;

  // control -> datapath
  typedef struct packed {
    logic load;      // write the slot picked by the index
    logic passAddr;  // drive the translated address out
  } ctrlStrobe_t;

  // datapath -> control: summary of the winning slot
  typedef struct packed {
    logic anyMatch;
    logic halfValid;
    logic halfDirty;
  } hitInfo_t;

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlbPkg::*;
#(
  parameter int NUM_ENTRIES   = 16,
  parameter int VA_W          = 32,
  parameter int PA_W          = 32,
  parameter int ASID_W        = 8,
  parameter int MIN_PAGE_BITS = 12,
  localparam int IDX_W        = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VA_W-1:0]   wrVpn,
  input  logic [VA_W-1:0]   wrMask,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [PA_W-1:0]   wrPfnEven,
  input  logic              wrValidEven,
  input  logic              wrDirtyEven,
  input  logic [PA_W-1:0]   wrPfnOdd,
  input  logic              wrValidOdd,
  input  logic              wrDirtyOdd,
  output hitInfo_t          hitInfo,
  output logic [PA_W-1:0]   physAddr
);

  // a page pair is two minimum pages: bits below PAIR_BITS are never tag bits
  localparam int PAIR_BITS = MIN_PAGE_BITS + 1;
  localparam logic [VA_W-1:0] PAIR_MASK = VA_W'((64'd1 << PAIR_BITS) - 64'd1);

  typedef struct packed {
    logic              used;
    logic              glob;
    logic [ASID_W-1:0] asid;
    logic [VA_W-1:0]   vpn;
    logic [VA_W-1:0]   cmpMask;
    logic [PA_W-1:0]   pfnEven;
    logic [PA_W-1:0]   pfnOdd;
    logic              validEven;
    logic              validOdd;
    logic              dirtyEven;
    logic              dirtyOdd;
  } entry_t;

  entry_t wrEntry;

  always_comb begin
    wrEntry.used      = 1'b1;
    wrEntry.glob      = wrGlobal;
    wrEntry.asid      = wrAsid;
    wrEntry.cmpMask   = wrMask | PAIR_MASK;
    wrEntry.vpn       = wrVpn & ~(wrMask | PAIR_MASK);
    wrEntry.pfnEven   = wrPfnEven;
    wrEntry.pfnOdd    = wrPfnOdd;
    wrEntry.validEven = wrValidEven;
    wrEntry.validOdd  = wrValidOdd;
    wrEntry.dirtyEven = wrDirtyEven;
    wrEntry.dirtyOdd  = wrDirtyOdd;
  end

  logic [NUM_ENTRIES-1:0] matchVec;
  logic [NUM_ENTRIES-1:0] halfValidVec;
  logic [NUM_ENTRIES-1:0] halfDirtyVec;
  logic [PA_W-1:0]        halfPa [NUM_ENTRIES];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gSlot
    entry_t          entQ;
    logic            loadHere;
    logic            tagHit;
    logic            asidOk;
    logic            oddSel;
    logic [VA_W-1:0] topBit;
    logic [VA_W-1:0] offVa;

    assign loadHere = strobe.load && (wrIndex == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         entQ <= '0;
      else if (loadHere) entQ <= wrEntry;
    end

    assign tagHit = ((lkVaddr & ~entQ.cmpMask) == entQ.vpn);
    assign asidOk = entQ.glob || (entQ.asid == curAsid);
    assign topBit = entQ.cmpMask & ~(entQ.cmpMask >> 1);
    assign oddSel = |(lkVaddr & topBit);
    assign offVa  = lkVaddr & (entQ.cmpMask >> 1);

    assign matchVec[i]     = entQ.used && tagHit && asidOk;
    assign halfValidVec[i] = oddSel ? entQ.validOdd : entQ.validEven;
    assign halfDirtyVec[i] = oddSel ? entQ.dirtyOdd : entQ.dirtyEven;
    assign halfPa[i]       = (oddSel ? entQ.pfnOdd : entQ.pfnEven) | PA_W'(offVa);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  logic [IDX_W-1:0] selIdx;
  always_comb begin
    selIdx = '0;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
      if (matchVec[k]) selIdx = IDX_W'(k);
    end
  end

  always_comb begin
    hitInfo.anyMatch  = |matchVec;
    hitInfo.halfValid = halfValidVec[selIdx];
    hitInfo.halfDirty = halfDirtyVec[selIdx];
  end

  assign physAddr = strobe.passAddr ? halfPa[selIdx] : '0;

endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlbPkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic             lkWrite,
  input  hitInfo_t         hitInfo,
  output ctrlStrobe_t      strobe,
  output lookupRes_e       result,
  output logic             writeOk
);

  logic idxInRange;

  if ((1 << IDX_W) == NUM_ENTRIES) begin : gFullIdx
    assign idxInRange = 1'b1;
  end else begin : gPartIdx
    assign idxInRange = (wrIndex < IDX_W'(NUM_ENTRIES));
  end

  always_comb begin
    if (!hitInfo.anyMatch)                 result = RES_MISS;
    else if (!hitInfo.halfValid)           result = RES_INVALID;
    else if (lkWrite && !hitInfo.halfDirty) result = RES_MODIFY;
    else                                   result = RES_HIT;
  end

  assign writeOk         = (result == RES_HIT) && hitInfo.halfDirty;
  assign strobe.load     = wrEn && idxInRange;
  assign strobe.passAddr = (result == RES_HIT);

endmodule

// File: rtl/dual_page_tlb.sv
module dual_page_tlb
  import tlbPkg::*;
#(
  parameter int NUM_ENTRIES   = 16,
  parameter int VA_W          = 32,
  parameter int PA_W          = 32,
  parameter int ASID_W        = 8,
  parameter int MIN_PAGE_BITS = 12,
  localparam int IDX_W        = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic              lkWrite,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VA_W-1:0]   wrVpn,
  input  logic [VA_W-1:0]   wrMask,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [PA_W-1:0]   wrPfnEven,
  input  logic              wrValidEven,
  input  logic              wrDirtyEven,
  input  logic [PA_W-1:0]   wrPfnOdd,
  input  logic              wrValidOdd,
  input  logic              wrDirtyOdd,
  output logic [PA_W-1:0]   physAddr,
  output logic              writeOk,
  output logic [1:0]        result
);

  ctrlStrobe_t strobe;
  hitInfo_t    hitInfo;
  lookupRes_e  resCode;

  tlb_datapath #(
    .NUM_ENTRIES  (NUM_ENTRIES),
    .VA_W         (VA_W),
    .PA_W         (PA_W),
    .ASID_W       (ASID_W),
    .MIN_PAGE_BITS(MIN_PAGE_BITS)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .lkVaddr    (lkVaddr),
    .curAsid    (curAsid),
    .wrIndex    (wrIndex),
    .wrVpn      (wrVpn),
    .wrMask     (wrMask),
    .wrAsid     (wrAsid),
    .wrGlobal   (wrGlobal),
    .wrPfnEven  (wrPfnEven),
    .wrValidEven(wrValidEven),
    .wrDirtyEven(wrDirtyEven),
    .wrPfnOdd   (wrPfnOdd),
    .wrValidOdd (wrValidOdd),
    .wrDirtyOdd (wrDirtyOdd),
    .hitInfo    (hitInfo),
    .physAddr   (physAddr)
  );

  tlb_control #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_control (
    .wrEn    (wrEn),
    .wrIndex (wrIndex),
    .lkWrite (lkWrite),
    .hitInfo (hitInfo),
    .strobe  (strobe),
    .result  (resCode),
    .writeOk (writeOk)
  );

  assign result = resCode;

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkWrite,
  input logic            wrEn,
  input logic [PA_W-1:0] physAddr,
  input logic            writeOk,
  input logic [1:0]      result
);

  logic anyLoaded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     anyLoaded <= 1'b0;
    else if (wrEn) anyLoaded <= 1'b1;
  end

  // R1: nothing loaded since reset means every lookup misses
  p_empty_miss_r1: assert property (@(posedge clk) disable iff (!rstN)
    !anyLoaded |-> (result == 2'b01));

  // R10: no translated address and no permission without a hit
  p_nohit_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (result != 2'b00) |-> (physAddr == '0 && !writeOk));

  // R7: permission implies a hit
  p_perm_needs_hit_r7: assert property (@(posedge clk) disable iff (!rstN)
    writeOk |-> (result == 2'b00));

  // R6: a modify fault only on a store
  p_modify_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    (result == 2'b11) |-> lkWrite);

  // R6: a store that hits always carries write permission
  p_store_hit_perm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (result == 2'b00 && lkWrite) |-> writeOk);

endmodule

bind dual_page_tlb tlb_checker #(.PA_W(PA_W)) u_tlbChk (
  .clk     (clk),
  .rstN    (rstN),
  .lkWrite (lkWrite),
  .wrEn    (wrEn),
  .physAddr(physAddr),
  .writeOk (writeOk),
  .result  (result)
);

// File: tb/tb_dual_page_tlb.sv
module tb_dual_page_tlb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic        lkWrite = 1'b0;
  logic [7:0]  curAsid = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIndex = '0;
  logic [31:0] wrVpn = '0;
  logic [31:0] wrMask = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrGlobal = 1'b0;
  logic [31:0] wrPfnEven = '0;
  logic        wrValidEven = 1'b0;
  logic        wrDirtyEven = 1'b0;
  logic [31:0] wrPfnOdd = '0;
  logic        wrValidOdd = 1'b0;
  logic        wrDirtyOdd = 1'b0;
  logic [31:0] physAddr;
  logic        writeOk;
  logic [1:0]  result;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  dual_page_tlb dut (
    .clk(clk), .rstN(rstN), .lkVaddr(lkVaddr), .lkWrite(lkWrite), .curAsid(curAsid),
    .wrEn(wrEn), .wrIndex(wrIndex), .wrVpn(wrVpn), .wrMask(wrMask), .wrAsid(wrAsid),
    .wrGlobal(wrGlobal), .wrPfnEven(wrPfnEven), .wrValidEven(wrValidEven),
    .wrDirtyEven(wrDirtyEven), .wrPfnOdd(wrPfnOdd), .wrValidOdd(wrValidOdd),
    .wrDirtyOdd(wrDirtyOdd), .physAddr(physAddr), .writeOk(writeOk), .result(result)
  );

  localparam logic [1:0] HIT = 2'b00, MISS = 2'b01, INV = 2'b10, MOD = 2'b11;

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [7:0]  asid;
    logic [1:0]  res;
    logic [31:0] pa;
    logic        wok;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0001_0123, 1'b0, 8'h05, HIT,  32'h0020_0123, 1'b1},
    '{32'h0001_1456, 1'b0, 8'h05, HIT,  32'h0030_0456, 1'b0},
    '{32'h0001_1456, 1'b1, 8'h05, MOD,  32'h0,         1'b0},
    '{32'h0001_0FFF, 1'b1, 8'h05, HIT,  32'h0020_0FFF, 1'b1},
    '{32'h0001_0123, 1'b0, 8'h07, HIT,  32'h0AA0_0123, 1'b1},
    '{32'h0001_1004, 1'b1, 8'h07, HIT,  32'h0BB0_0004, 1'b1},
    '{32'h0040_3ABC, 1'b0, 8'h33, HIT,  32'h0100_3ABC, 1'b0},
    '{32'h0040_3ABC, 1'b1, 8'h33, MOD,  32'h0,         1'b0},
    '{32'h0040_4010, 1'b0, 8'h33, INV,  32'h0,         1'b0},
    '{32'h0040_7FFF, 1'b1, 8'h33, INV,  32'h0,         1'b0},
    '{32'h0040_8000, 1'b0, 8'h33, MISS, 32'h0,         1'b0},
    '{32'h0001_2000, 1'b0, 8'h05, MISS, 32'h0,         1'b0},
    '{32'h0041_0000, 1'b0, 8'h05, MISS, 32'h0,         1'b0}
  };

  function automatic string vecTag(int i);
    case (i)
      0:       return "R9 R7 even hit, low slot wins";
      1:       return "R4 odd half, 4 KB";
      2:       return "R6 store to clean half";
      3:       return "R6 store to dirty half";
      4:       return "R2 other ASID falls to global slot";
      5:       return "R2 global slot odd store";
      6:       return "R3 16 KB even half offset";
      7:       return "R6 store to clean 16 KB half";
      8:       return "R4 R5 bit 14 picks invalid odd half";
      9:       return "R5 store to invalid half";
      10:      return "R3 R8 tag bit 15 differs";
      11:      return "R8 R10 tag miss";
      default: return "R8 unmapped address";
    endcase
  endfunction

  task automatic checkOut(string tag, logic [1:0] expRes, logic [31:0] expPa, logic expWok);
    total++;
    if (result !== expRes || physAddr !== expPa || writeOk !== expWok) begin
      bad++;
      $display("FAIL %s: got res=%b pa=%h wok=%b, expected res=%b pa=%h wok=%b",
               tag, result, physAddr, writeOk, expRes, expPa, expWok);
    end
  endtask

  task automatic lookup(logic [31:0] va, logic wr, logic [7:0] asid);
    @(negedge clk);
    lkVaddr = va;
    lkWrite = wr;
    curAsid = asid;
    #2;
  endtask

  task automatic loadSlot(logic [3:0] idx, logic [31:0] vpn, logic [31:0] mask,
                          logic [7:0] asid, logic glob,
                          logic [31:0] pfnE, logic vE, logic dE,
                          logic [31:0] pfnO, logic vO, logic dO);
    @(negedge clk);
    wrIndex = idx;  wrVpn = vpn;  wrMask = mask;  wrAsid = asid;  wrGlobal = glob;
    wrPfnEven = pfnE;  wrValidEven = vE;  wrDirtyEven = dE;
    wrPfnOdd = pfnO;   wrValidOdd = vO;   wrDirtyOdd = dO;
    wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset and after release, nothing matches
    lookup(32'h0001_0123, 1'b0, 8'h05);
    checkOut("R1 in reset", MISS, 32'h0, 1'b0);
    rstN = 1'b1;
    lookup(32'h0000_0000, 1'b0, 8'h00);
    checkOut("R1 after reset, address 0", MISS, 32'h0, 1'b0);

    // R11: load the table
    loadSlot(4'd0, 32'h0001_0000, 32'h0, 8'h05, 1'b0,
             32'h0020_0000, 1'b1, 1'b1, 32'h0030_0000, 1'b1, 1'b0);
    loadSlot(4'd1, 32'h0040_0000, 32'h0000_6000, 8'h00, 1'b1,
             32'h0100_0000, 1'b1, 1'b0, 32'h0200_0000, 1'b0, 1'b1);
    loadSlot(4'd5, 32'h0001_0000, 32'h0, 8'h09, 1'b1,
             32'h0AA0_0000, 1'b1, 1'b1, 32'h0BB0_0000, 1'b1, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      lookup(VECS[i].va, VECS[i].wr, VECS[i].asid);
      checkOut(vecTag(i), VECS[i].res, VECS[i].pa, VECS[i].wok);
    end

    // R2: ASID mismatch on a non-global slot with no other candidate
    loadSlot(4'd7, 32'h0070_0000, 32'h0, 8'h21, 1'b0,
             32'h0700_0000, 1'b1, 1'b1, 32'h0710_0000, 1'b1, 1'b1);
    lookup(32'h0070_0010, 1'b0, 8'h22);
    checkOut("R2 ASID mismatch misses", MISS, 32'h0, 1'b0);
    lookup(32'h0070_0010, 1'b0, 8'h21);
    checkOut("R2 ASID equal hits", HIT, 32'h0700_0010, 1'b1);

    // R11: overwrite slot 0; the old pair now falls through to slot 5
    loadSlot(4'd0, 32'h0002_0000, 32'h0, 8'h05, 1'b0,
             32'h0060_0000, 1'b1, 1'b0, 32'h0061_0000, 1'b1, 1'b0);
    lookup(32'h0001_0123, 1'b0, 8'h05);
    checkOut("R11 R9 old tag goes to slot 5", HIT, 32'h0AA0_0123, 1'b1);
    lookup(32'h0002_1010, 1'b0, 8'h05);
    checkOut("R11 new contents odd half", HIT, 32'h0061_0010, 1'b0);

    // R1: reset mid-run clears every slot
    @(negedge clk);
    rstN = 1'b0;
    #2;
    rstN = 1'b1;
    lookup(32'h0040_3ABC, 1'b0, 8'h33);
    checkOut("R1 global slot gone after reset", MISS, 32'h0, 1'b0);
    lookup(32'h0070_0010, 1'b0, 8'h21);
    checkOut("R1 ASID slot gone after reset", MISS, 32'h0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule